// File: doc/BRIEF.md
# Interrupt Enable and Dispatch Unit

This block decides when a small 8-bit processor core must stop its normal instruction flow and enter an interrupt service routine. It holds a five-bit source enable register and a five-bit pending-request register. It also runs a three-state master enable (off, armed, on). Peripherals pulse one request line per source. The core reports every instruction that retires, and flags whether that instruction was an enable-interrupts, disable-interrupts or return-from-interrupt instruction.

When the master enable is on and at least one enabled source is pending, the block raises a take request. It also shows the vector address and the index of the winning source. The core answers with a one-cycle acknowledge. On that cycle the block clears the winning pending bit and drops the master enable to off. The core handles the stack push and the fetch from the vector.

The enable-interrupts instruction only arms the master enable. The enable becomes active one instruction later, and a disable-interrupts instruction that retires in between cancels it.

Top module: `irq_dispatch_unit`

## Requirements
- R1: After reset, the master state is off (code 0), the enable register and the pending register are all zeros, and `take_req` is low.
- R2: When an enable-interrupts instruction retires while the state is off, the state becomes armed (code 1). `take_req` is never high while the state is armed.
- R3: When a disable-interrupts instruction retires, the state becomes off. This holds from armed and from on. No take request follows, even with all five sources enabled and pending.
- R4: In the armed state, the next retiring instruction that is not a disable-interrupts instruction moves the state to on (code 2). An enable-interrupts instruction retiring while the state is on leaves it on.
- R5: When a return-from-interrupt instruction retires, the state becomes on at once, whatever the state was before.
- R6: A pulse on `src_req[i]` sets pending bit i, whatever the enables and the master state are. Bit order: 0 vertical blank, 1 display status, 2 timer, 3 serial, 4 joypad. A set and a clear of the same bit in the same cycle leave the bit set.
- R7: `take_req` is high exactly when the state is on and the AND of the enable register and the pending register is nonzero.
- R8: While `take_req` is high, `svc_idx` is the lowest-numbered source that is both enabled and pending. `vec_addr` is 0x40 + 8 × `svc_idx`, which gives 0x40, 0x48, 0x50, 0x58 and 0x60.
- R9: An acknowledge while `take_req` is high clears only the serviced pending bit, and the state is off on the next cycle. The acknowledge takes priority over any instruction retiring in the same cycle.
- R10: An acknowledge while `take_req` is low changes neither the pending register nor the state.
- R11: When `en_wr` is high, `en_wdata` is loaded into the enable register on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 5 | One-cycle request pulses from the peripherals |
| retire | input | 1 | An instruction retires this cycle |
| op_ei | input | 1 | The retiring instruction is enable-interrupts |
| op_di | input | 1 | The retiring instruction is disable-interrupts |
| op_reti | input | 1 | The retiring instruction is return-from-interrupt |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 5 | Write data for the enable register |
| take_ack | input | 1 | One-cycle acknowledge of a dispatch from the core |
| take_req | output | 1 | Dispatch wanted |
| vec_addr | output | 8 | Vector address of the winning source |
| svc_idx | output | 3 | Index of the winning source |
| ie_q | output | 5 | Current enable register |
| if_q | output | 5 | Current pending register |
| ime_st | output | 2 | Master state: 0 off, 1 armed, 2 on |

## Verification
A wrong master state reaches the ports within one cycle. It shows on `ime_st` straight after the retire that caused it. It also shows on `take_req` as soon as an enabled source is pending: a take request from the armed state, or a missing take request after the arming instruction is followed by another retire. A wrong priority or clear shows at once as a wrong `vec_addr` or `svc_idx`. It also shows one cycle after the acknowledge, as a pending bit that stays set or a neighbour bit that has vanished. The bench compares every output against its own model on every cycle, so each of these errors is reported in the cycle it first appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      MST_OFF   = 2'd0,
      MST_ARMED = 2'd1,
      MST_ON    = 2'd2
   } mst_state_t;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int N_SRC = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [N_SRC-1:0] wdata_i,
   output logic [N_SRC-1:0] en_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    en_o <= '0;
      else if (wr_i) en_o <= wdata_i;
   end

   a_r11_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> en_o == $past(wdata_i));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N_SRC = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flags_o
);
   for (genvar b = 0; b < N_SRC; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)        flags_o[b] <= 1'b0;
         else if (set_i[b]) flags_o[b] <= 1'b1;   // set beats clear
         else if (clr_i[b]) flags_o[b] <= 1'b0;
      end

      a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> flags_o[b]);
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N_SRC     = 5,
   parameter int IDX_W     = 3,
   parameter int VEC_W     = 8,
   parameter int VEC_BASE  = 'h40,
   parameter int VEC_STEP  = 8
) (
   input  logic [N_SRC-1:0] cand_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N_SRC-1:0] onehot_o,
   output logic [VEC_W-1:0] vec_o
);
   int vec_full;

   always_comb begin
      idx_o    = '0;
      onehot_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (cand_i[i]) begin
            idx_o    = IDX_W'(i);
            onehot_o = '0;
            onehot_o[i] = 1'b1;
         end
      end
      any_o    = |cand_i;
      vec_full = VEC_BASE + int'(idx_o) * VEC_STEP;
      vec_o    = vec_full[VEC_W-1:0];
   end
endmodule

// File: rtl/irq_master_fsm.sv
module irq_master_fsm
   import irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       retire_i,
   input  logic       ei_i,
   input  logic       di_i,
   input  logic       reti_i,
   input  logic       dispatch_i,
   output mst_state_t state_o
);
   mst_state_t nxt;

   always_comb begin
      nxt = state_o;
      if (dispatch_i)             nxt = MST_OFF;
      else if (retire_i) begin
         if (reti_i)              nxt = MST_ON;
         else if (di_i)           nxt = MST_OFF;
         else if (state_o == MST_ARMED) nxt = MST_ON;
         else if (ei_i && state_o == MST_OFF) nxt = MST_ARMED;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_o <= MST_OFF;
      else        state_o <= nxt;
   end

   a_r2_ei_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && ei_i && !di_i && !reti_i && !dispatch_i && state_o == MST_OFF)
      |=> state_o == MST_ARMED);
   a_r3_di_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && di_i && !reti_i) |=> state_o == MST_OFF);
   a_r4_armed_to_on: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == MST_ARMED && retire_i && !di_i && !dispatch_i) |=> state_o == MST_ON);
   a_r5_reti_on: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && reti_i && !dispatch_i) |=> state_o == MST_ON);
   a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'd3);
endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit
   import irq_pkg::*;
#(
   parameter int N_SRC    = 5,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 'h40,
   parameter int VEC_STEP = 8,
   parameter int IDX_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic             retire,
   input  logic             op_ei,
   input  logic             op_di,
   input  logic             op_reti,
   input  logic             en_wr,
   input  logic [N_SRC-1:0] en_wdata,
   input  logic             take_ack,
   output logic             take_req,
   output logic [VEC_W-1:0] vec_addr,
   output logic [IDX_W-1:0] svc_idx,
   output logic [N_SRC-1:0] ie_q,
   output logic [N_SRC-1:0] if_q,
   output logic [1:0]       ime_st
);
   localparam int LAST_VEC = VEC_BASE + (N_SRC - 1) * VEC_STEP;

   if (N_SRC < 1 || N_SRC > (1 << IDX_W)) begin : g_bad_nsrc
      $error("N_SRC does not fit IDX_W");
   end
   if (LAST_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector table exceeds VEC_W");
   end

   mst_state_t       state;
   logic [N_SRC-1:0] cand, win_1h, clr;
   logic             any_cand, dispatch;

   irq_enable_reg #(.N_SRC(N_SRC)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_i(en_wr), .wdata_i(en_wdata), .en_o(ie_q));

   irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(src_req), .clr_i(clr), .flags_o(if_q));

   assign cand = ie_q & if_q;

   irq_prio_pick #(
      .N_SRC(N_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
      .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
   ) u_pick (
      .cand_i(cand), .any_o(any_cand), .idx_o(svc_idx),
      .onehot_o(win_1h), .vec_o(vec_addr));

   assign take_req = any_cand && (state == MST_ON);
   assign dispatch = take_req && take_ack;
   assign clr      = dispatch ? win_1h : '0;

   irq_master_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .retire_i(retire), .ei_i(op_ei), .di_i(op_di),
      .reti_i(op_reti), .dispatch_i(dispatch), .state_o(state));

   assign ime_st = state;

   a_r7_take_only_on: assert property (@(posedge clk) disable iff (!rst_n)
      take_req |-> (ime_st == 2'd2 && (ie_q & if_q) != '0));
   a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr));
   a_r8_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
      take_req |-> (ie_q[svc_idx] && if_q[svc_idx]));
   a_r9_ack_turns_off: assert property (@(posedge clk) disable iff (!rst_n)
      (take_req && take_ack) |=> ime_st == 2'd0);
   a_r10_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_req && take_ack && !retire && src_req == '0) |=> $stable(if_q) && $stable(ime_st));
endmodule

// File: tb/irq_dispatch_unit_test.sv
`timescale 1ns/1ps
module irq_dispatch_unit_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] src_req, en_wdata;
   logic       retire, op_ei, op_di, op_reti, en_wr, take_ack;
   logic       take_req;
   logic [7:0] vec_addr;
   logic [2:0] svc_idx;
   logic [4:0] ie_q, if_q;
   logic [1:0] ime_st;

   int checks = 0, errors = 0, cyc = 0;
   logic [4:0] m_ie, m_if;
   logic [1:0] m_st;

   always #2 clk = ~clk;

   irq_dispatch_unit uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .retire(retire), .op_ei(op_ei),
      .op_di(op_di), .op_reti(op_reti), .en_wr(en_wr), .en_wdata(en_wdata),
      .take_ack(take_ack), .take_req(take_req), .vec_addr(vec_addr), .svc_idx(svc_idx),
      .ie_q(ie_q), .if_q(if_q), .ime_st(ime_st));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic int low_idx(input logic [4:0] m);
      for (int i = 0; i < 5; i++) if (m[i]) return i;
      return 0;
   endfunction

   function automatic logic m_take();
      return (m_st == 2'd2) && ((m_ie & m_if) != 5'd0);
   endfunction

   task automatic tick(input logic [4:0] rq, input logic rt, input logic ei,
                       input logic di, input logic rti, input logic ack,
                       input logic wr, input logic [4:0] wd);
      logic disp;
      logic [4:0] clr;
      @(negedge clk);
      src_req = rq; retire = rt; op_ei = ei; op_di = di; op_reti = rti;
      take_ack = ack; en_wr = wr; en_wdata = wd;
      #1;
      chk("R7 take_req", int'(take_req), int'(m_take()));
      if (m_take()) begin
         chk("R8 svc_idx", int'(svc_idx), low_idx(m_ie & m_if));
         chk("R8 vec_addr", int'(vec_addr), 'h40 + 8 * low_idx(m_ie & m_if));
      end
      disp = m_take() && ack;
      clr  = '0;
      if (disp) clr[low_idx(m_ie & m_if)] = 1'b1;
      @(posedge clk);
      m_if = (m_if & ~clr) | rq;
      if (wr) m_ie = wd;
      if (disp) m_st = 2'd0;
      else if (rt) begin
         if (rti)                     m_st = 2'd2;
         else if (di)                 m_st = 2'd0;
         else if (m_st == 2'd1)       m_st = 2'd2;
         else if (ei && m_st == 2'd0) m_st = 2'd1;
      end
      #1;
      chk("R6 if_q", int'(if_q), int'(m_if));
      chk("R11 ie_q", int'(ie_q), int'(m_ie));
      chk("R2 ime_st", int'(ime_st), int'(m_st));
      #1;
      src_req = '0; retire = 0; op_ei = 0; op_di = 0; op_reti = 0;
      take_ack = 0; en_wr = 0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; src_req = '0; retire = 0; op_ei = 0; op_di = 0; op_reti = 0;
      en_wr = 0; en_wdata = '0; take_ack = 0;
      m_ie = '0; m_if = '0; m_st = 2'd0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R1 ime_st", int'(ime_st), 0);
      chk("R1 ie_q", int'(ie_q), 0);
      chk("R1 if_q", int'(if_q), 0);
      chk("R1 take_req", int'(take_req), 0);

      // all sources enabled and pending, master off
      tick(5'h1F, 0, 0, 0, 0, 0, 1, 5'h1F);
      chk("R6 all pending", int'(if_q), 'h1F);
      // EI then DI: armed, then cancelled
      tick(0, 1, 1, 0, 0, 0, 0, 0);
      chk("R2 armed", int'(ime_st), 1);
      chk("R2 no take while armed", int'(take_req), 0);
      tick(0, 1, 0, 1, 0, 0, 0, 0);
      chk("R3 cancelled", int'(ime_st), 0);
      for (int k = 0; k < 3; k++) begin
         tick(0, 1, 0, 0, 0, 0, 0, 0);
         chk("R3 stays off", int'(take_req), 0);
      end
      // EI then plain instruction: on
      tick(0, 1, 1, 0, 0, 0, 0, 0);
      tick(0, 1, 0, 0, 0, 0, 0, 0);
      chk("R4 on", int'(ime_st), 2);
      tick(0, 1, 1, 0, 0, 0, 0, 0);
      chk("R4 ei keeps on", int'(ime_st), 2);
      // dispatch each source in priority order via RETI
      for (int s = 0; s < 5; s++) begin
         if (s > 0) begin
            tick(0, 1, 0, 0, 1, 0, 0, 0);
            chk("R5 reti on", int'(ime_st), 2);
         end
         #1 chk("R8 vector", int'(vec_addr), 'h40 + 8 * s);
         tick(0, 1, 1, 0, 0, 1, 0, 0);   // ack wins over a retire
         chk("R9 flag cleared", int'(if_q), int'(5'h1F & ~((5'h2 << s) - 5'h1)));
         chk("R9 off after ack", int'(ime_st), 0);
      end
      // ack with no take request
      tick(5'h04, 0, 0, 0, 0, 0, 0, 0);
      tick(0, 0, 0, 0, 0, 1, 0, 0);
      chk("R10 ack ignored flag", int'(if_q), 'h04);
      chk("R10 ack ignored state", int'(ime_st), 0);
      // DI from on
      tick(0, 1, 0, 0, 1, 0, 1, 5'h00);
      tick(0, 1, 0, 1, 0, 0, 0, 0);
      chk("R3 di from on", int'(ime_st), 0);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] rq;
         logic rt, e, d, r, a, w;
         int op;
         rq = ($urandom % 6 == 0) ? 5'($urandom) : 5'd0;
         rt = ($urandom % 2) == 0;
         op = $urandom % 6;
         e = (op == 0); d = (op == 1); r = (op == 2);
         a = m_take() ? ($urandom % 3 != 0) : ($urandom % 8 == 0);
         w = ($urandom % 16) == 0;
         tick(rq, rt, e, d, r, a, w, 5'($urandom));
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule